// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block makes sure every row of an SDRAM device is refreshed inside the retention window. A fractional accumulator turns a configured window length and row count into a stream of refresh deadlines. Every tick adds the row count to the accumulator, and each time the sum reaches the window length one more refresh becomes owed. Over any window of `cfg_window` ticks, exactly `cfg_rows` refreshes fall due, so no divider is needed. Owed refreshes are counted in a bounded pending counter.

While refreshes are owed, the block asks the main command arbiter for the command slot. The request is low priority while the backlog is below its limit and becomes urgent at the limit. Once granted, the block closes any open bank with a precharge-all command and waits the precharge time. It then issues REFRESH and holds off ACTIVATE for the refresh cycle time. A backlog that reached its limit is drained in catch-up mode, with refreshes issued back-to-back one refresh cycle time apart until nothing is owed. A mirror of the device's internal refresh row counter is kept, and it pulses a flag each time a full sweep of the rows completes.

The arbiter keeps the grant while `ref_req` stays high, and `ref_req` stays high for the whole precharge/refresh sequence. Commands come out as single-cycle strobes qualified by the grant. The block applies no back-pressure of its own: a command is taken in the cycle it is shown.

Top module: `refresh_sched`

## Requirements
- R1: After reset, `ref_req`, `ref_urgent`, `cmd_valid`, `act_block` and `sweep_done` are low, and `pending` and `row_shadow` are zero.
- R2: On a cycle with `tick` high, `pending` rises by one when the accumulator plus `cfg_rows` reaches `cfg_window`, so exactly `cfg_rows` refreshes fall due per `cfg_window` ticks. Cycles with `tick` low add nothing.
- R3: `pending` never exceeds MAX_PEND (default 8) and saturates there. `ref_req` is high in the idle state whenever `pending` is non-zero. `ref_urgent` is high whenever `pending` equals MAX_PEND.
- R4: When the idle block is granted with `pending` non-zero and all bits of `bank_open` low, `cmd_valid` is high in that same cycle with `cmd_op` = 2'b10 (REFRESH), and `pending` drops by one.
- R5: When granted while any bit of `bank_open` is high, the block first issues `cmd_op` = 2'b01 (precharge all). REFRESH follows exactly T_RP cycles later if the grant is still held.
- R6: After a REFRESH, `act_block` is high for the next T_RFC-1 cycles, and no command is issued while it is high.
- R7: `ref_req` stays high from the first command of a sequence until the blackout after its last REFRESH has ended.
- R8: `row_shadow` advances by one on each REFRESH and changes at no other time. It wraps from `cfg_rows`-1 to zero, and `sweep_done` is high for the one cycle following the wrapping REFRESH.
- R9: Once `pending` reaches MAX_PEND, `ref_urgent` stays high until `pending` returns to zero. While the grant is held, REFRESH commands are issued exactly T_RFC cycles apart until the backlog is drained.
- R10: With an arbiter that grants every request and no open banks, a full sweep of `cfg_rows` rows completes once per `cfg_window` ticks.
- R11: No command is issued in a cycle where `ref_gnt` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time base qualifier for the refresh accumulator |
| cfg_rows | input | ROW_W | Rows per sweep (1..cfg_window) |
| cfg_window | input | WIN_W | Retention window in ticks |
| bank_open | input | NUM_BANKS | One bit per bank with an open row |
| ref_req | output | 1 | Request for the command slot |
| ref_urgent | output | 1 | Request must be honoured before other traffic |
| ref_gnt | input | 1 | Command slot granted by the arbiter |
| cmd_valid | output | 1 | Command strobe |
| cmd_op | output | 2 | 2'b01 precharge all, 2'b10 refresh |
| act_block | output | 1 | ACTIVATE forbidden (refresh blackout) |
| pending | output | PEND_W | Refreshes owed |
| row_shadow | output | ROW_W | Mirror of the device refresh row counter |
| sweep_done | output | 1 | One-cycle pulse when the row mirror wraps |

## Verification
The bench targets the boundary where the backlog saturates. A design that wraps the counter there instead of holding it would lose owed refreshes, and one that drops urgency one refresh too early would stop catch-up with rows still owed. It opens banks just before a grant to check that precharge-all comes first and that REFRESH follows after exactly the precharge time. A design that skipped the close or miscounted the wait would show up as a wrong command or a wrong gap. It also checks that refresh pairs in catch-up are exactly the blackout apart, that the row mirror wraps at the configured count rather than at its full width, and that gating the tick freezes the backlog.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PREA = 2'b01,
    OP_REF  = 2'b10
  } ref_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PRE  = 2'b01,
    ST_RFC  = 2'b10
  } seq_st_e;
endpackage

// File: rtl/refresh_interval_gen.sv
module refresh_interval_gen #(
  parameter int ROW_W = 16,
  parameter int WIN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [ROW_W-1:0] cfg_rows,
  input  logic [WIN_W-1:0] cfg_window,
  output logic             expire
);
  localparam int SUM_W = WIN_W + 1;

  logic [WIN_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;
  logic             reach;

  // fractional accumulator: cfg_rows deadlines per cfg_window ticks
  assign sum    = {1'b0, acc_q} + SUM_W'(cfg_rows);
  assign reach  = (sum >= {1'b0, cfg_window});
  assign expire = tick && reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (tick) begin
      if (reach) acc_q <= WIN_W'(sum - {1'b0, cfg_window});
      else       acc_q <= WIN_W'(sum);
    end
  end
endmodule

// File: rtl/refresh_pend_ctr.sv
module refresh_pend_ctr #(
  parameter int MAX_PEND = 8,
  parameter int PEND_W   = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              ref_fire,
  output logic [PEND_W-1:0] pend,
  output logic              burst,
  output logic              urgent
);
  localparam logic [PEND_W-1:0] PMAX = PEND_W'(MAX_PEND);

  logic at_max;
  assign at_max = (pend == PMAX);
  assign urgent = burst || at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      case ({expire, ref_fire})
        2'b10:   if (!at_max) pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  // catch-up latch: engaged at the limit, released once drained
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              burst <= 1'b0;
    else if (at_max)         burst <= 1'b1;
    else if (pend == '0)     burst <= 1'b0;
  end
endmodule

// File: rtl/refresh_row_mirror.sv
module refresh_row_mirror #(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_fire,
  input  logic [ROW_W-1:0] cfg_rows,
  output logic [ROW_W-1:0] row,
  output logic             sweep
);
  logic last_row;
  assign last_row = (row >= (cfg_rows - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row   <= '0;
      sweep <= 1'b0;
    end else begin
      sweep <= ref_fire && last_row;
      if (ref_fire) row <= last_row ? '0 : row + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_seq_fsm.sv
module refresh_seq_fsm
  import refresh_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int PEND_W    = 4,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PEND_W-1:0]    pend,
  input  logic                 burst,
  input  logic                 gnt,
  input  logic [NUM_BANKS-1:0] bank_open,
  output logic                 req,
  output logic                 cmd_valid,
  output logic [1:0]           cmd_op,
  output logic                 act_block,
  output logic                 ref_fire
);
  localparam int CMAX  = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(T_RFC - 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             owed, cnt_zero, more, start_ok, issue;
  ref_op_e          op;

  assign owed     = (pend != '0);
  assign cnt_zero = (cnt_q == '0);
  assign more     = burst && owed;

  // a new sequence may begin from idle, or chain inside catch-up
  assign start_ok = (st_q == ST_IDLE && owed) ||
                    (st_q == ST_RFC && cnt_zero && more);

  always_comb begin
    req = 1'b0;
    case (st_q)
      ST_IDLE: req = owed;
      ST_PRE:  req = 1'b1;
      ST_RFC:  req = !cnt_zero || more;
      default: req = 1'b0;
    endcase
  end

  always_comb begin
    if (st_q == ST_PRE) op = OP_REF;
    else                op = (|bank_open) ? OP_PREA : OP_REF;
  end

  assign issue     = gnt && (start_ok || (st_q == ST_PRE && cnt_zero));
  assign cmd_valid = issue;
  assign cmd_op    = issue ? op : OP_NONE;
  assign ref_fire  = issue && (op == OP_REF);
  assign act_block = (st_q == ST_RFC) && !cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (issue) begin
            st_q  <= (op == OP_PREA) ? ST_PRE : ST_RFC;
            cnt_q <= (op == OP_PREA) ? RP_LD : RFC_LD;
          end
        end
        ST_PRE: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (issue) begin
            st_q  <= ST_RFC;
            cnt_q <= RFC_LD;
          end
        end
        ST_RFC: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (issue) begin
            st_q  <= (op == OP_PREA) ? ST_PRE : ST_RFC;
            cnt_q <= (op == OP_PREA) ? RP_LD : RFC_LD;
          end else if (!more) begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int ROW_W     = 16,
  parameter int WIN_W     = 24,
  parameter int NUM_BANKS = 8,
  parameter int MAX_PEND  = 8,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 8,
  localparam int PEND_W   = $clog2(MAX_PEND + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [ROW_W-1:0]     cfg_rows,
  input  logic [WIN_W-1:0]     cfg_window,
  input  logic [NUM_BANKS-1:0] bank_open,
  output logic                 ref_req,
  output logic                 ref_urgent,
  input  logic                 ref_gnt,
  output logic                 cmd_valid,
  output logic [1:0]           cmd_op,
  output logic                 act_block,
  output logic [PEND_W-1:0]    pending,
  output logic [ROW_W-1:0]     row_shadow,
  output logic                 sweep_done
);
  logic expire, ref_fire, burst;

  refresh_interval_gen #(.ROW_W(ROW_W), .WIN_W(WIN_W)) u_ivl (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cfg_rows(cfg_rows), .cfg_window(cfg_window), .expire(expire)
  );

  refresh_pend_ctr #(.MAX_PEND(MAX_PEND), .PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .expire(expire), .ref_fire(ref_fire),
    .pend(pending), .burst(burst), .urgent(ref_urgent)
  );

  refresh_seq_fsm #(.NUM_BANKS(NUM_BANKS), .PEND_W(PEND_W),
                    .T_RP(T_RP), .T_RFC(T_RFC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pend(pending), .burst(burst),
    .gnt(ref_gnt), .bank_open(bank_open), .req(ref_req),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .act_block(act_block),
    .ref_fire(ref_fire)
  );

  refresh_row_mirror #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .ref_fire(ref_fire), .cfg_rows(cfg_rows),
    .row(row_shadow), .sweep(sweep_done)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int ROW_W    = 16,
  parameter int MAX_PEND = 8,
  localparam int PEND_W  = $clog2(MAX_PEND + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_req,
  input logic              ref_urgent,
  input logic              ref_gnt,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              act_block,
  input logic [PEND_W-1:0] pending,
  input logic [ROW_W-1:0]  row_shadow,
  input logic              sweep_done
);
  localparam logic [PEND_W-1:0] PMAX = PEND_W'(MAX_PEND);

  p_cmd_needs_gnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ref_gnt);

  p_pend_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= PMAX);

  p_full_is_urgent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == PMAX) |-> (ref_urgent && ref_req));

  p_ref_starts_blackout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b10) |=> act_block);

  p_quiet_in_blackout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_block |-> !cmd_valid);

  p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act_block |-> ref_req);

  p_row_only_on_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op == 2'b10) |=> $stable(row_shadow));

  p_sweep_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> (row_shadow == '0));

  p_op_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op == 2'b01 || cmd_op == 2'b10));
endmodule

bind refresh_sched refresh_sched_chk #(.ROW_W(ROW_W), .MAX_PEND(MAX_PEND)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_urgent(ref_urgent),
  .ref_gnt(ref_gnt), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .act_block(act_block), .pending(pending), .row_shadow(row_shadow),
  .sweep_done(sweep_done)
);

// File: tb/tb_refresh_sched.sv
`timescale 1ns/1ps
module tb_refresh_sched;
  localparam int ROW_W = 16, WIN_W = 24, NB = 8, MAXP = 8, TRP = 3, TRFC = 8;
  localparam int ROWS = 8, WIN = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [ROW_W-1:0] cfg_rows = ROW_W'(ROWS);
  logic [WIN_W-1:0] cfg_window = WIN_W'(WIN);
  logic [NB-1:0] bank_open = '0;
  logic [NB-1:0] reopen = '0;
  logic [1:0] gmode = 2'd1;   // 1: grant any request, 0: urgent only, 2: none
  logic ref_req, ref_urgent, ref_gnt, cmd_valid, act_block, sweep_done;
  logic [1:0] cmd_op;
  logic [3:0] pending;
  logic [ROW_W-1:0] row_shadow;

  always #5 clk = ~clk;

  assign ref_gnt = ref_req && (gmode == 2'd1 || (gmode == 2'd0 && ref_urgent));

  refresh_sched dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_rows(cfg_rows),
    .cfg_window(cfg_window), .bank_open(bank_open), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .ref_gnt(ref_gnt), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .act_block(act_block), .pending(pending),
    .row_shadow(row_shadow), .sweep_done(sweep_done)
  );

  // environment: precharge-all closes banks; banks open only while idle
  always @(posedge clk) begin
    if (cmd_valid && cmd_op == 2'b01) bank_open <= '0;
    else if (!ref_req && reopen != '0) bank_open <= reopen;
  end

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference: owed refreshes, sequence phase, row mirror
  int m_acc = 0, m_pend = 0, m_phase = 0, m_wait = 0, m_row = 0;
  bit m_catch = 0, m_sweep = 0;
  // directed monitors
  int last_op = 0, last_cmd_cyc = 0, last_ref_cyc = -100;
  int ref_cnt = 0, sweep_cnt = 0, b2b_cnt = 0, prea_cnt = 0;

  always @(negedge clk) begin
    bit m_req, m_urg, m_gnt, m_iss, due, fire;
    int m_op, nxt;
    cyc++;
    m_req = (m_phase == 0 && m_pend > 0) || m_phase == 1 ||
            (m_phase == 2 && (m_wait > 0 || (m_catch && m_pend > 0)));
    m_urg = m_catch || m_pend == MAXP;
    m_gnt = m_req && (gmode == 2'd1 || (gmode == 2'd0 && m_urg));
    m_iss = m_gnt && ((m_phase == 0 && m_pend > 0) || (m_phase == 1 && m_wait == 0) ||
                      (m_phase == 2 && m_wait == 0 && m_catch && m_pend > 0));
    m_op  = (m_phase == 1) ? 2 : ((bank_open != '0) ? 1 : 2);
    if (!m_iss) m_op = 0;

    chk(ref_req == m_req, "R3/R7 ref_req", ref_req, m_req);
    chk(ref_urgent == m_urg, "R3/R9 ref_urgent", ref_urgent, m_urg);
    chk(cmd_valid == m_iss, "R4/R11 cmd_valid", cmd_valid, m_iss);
    chk(cmd_op == 2'(m_op), "R4/R5 cmd_op", cmd_op, m_op);
    chk(act_block == (m_phase == 2 && m_wait > 0), "R6 act_block", act_block, m_phase == 2 && m_wait > 0);
    chk(pending == 4'(m_pend), "R2 pending", pending, m_pend);
    chk(row_shadow == ROW_W'(m_row), "R8 row_shadow", row_shadow, m_row);
    chk(sweep_done == m_sweep, "R8 sweep_done", sweep_done, m_sweep);

    // directed timing monitors on the ports
    if (cmd_valid && cmd_op == 2'b10) begin
      if (last_op == 1) chk(cyc - last_cmd_cyc == TRP, "R5 prea-to-ref gap", cyc - last_cmd_cyc, TRP);
      chk(cyc - last_ref_cyc >= TRFC, "R6 ref-to-ref gap", cyc - last_ref_cyc, TRFC);
      if (cyc - last_ref_cyc == TRFC && ref_urgent) b2b_cnt++;
      last_ref_cyc = cyc;
      ref_cnt++;
    end
    if (cmd_valid) begin
      if (cmd_op == 2'b01) prea_cnt++;
      last_op = cmd_op;
      last_cmd_cyc = cyc;
    end
    if (sweep_done) sweep_cnt++;

    // advance the reference
    if (!rst_n) begin
      m_acc = 0; m_pend = 0; m_phase = 0; m_wait = 0; m_row = 0; m_catch = 0; m_sweep = 0;
    end else begin
      due = 0;
      if (tick) begin
        if (m_acc + ROWS >= WIN) begin due = 1; m_acc = m_acc + ROWS - WIN; end
        else m_acc = m_acc + ROWS;
      end
      fire = m_iss && m_op == 2;
      if (m_pend == MAXP) m_catch = 1; else if (m_pend == 0) m_catch = 0;
      nxt = m_pend + (due ? 1 : 0) - (fire ? 1 : 0);
      m_pend = (nxt > MAXP) ? MAXP : nxt;
      m_sweep = 0;
      if (fire) begin
        if (m_row >= ROWS - 1) begin m_row = 0; m_sweep = 1; end
        else m_row++;
      end
      if (m_phase == 1 && m_wait > 0) m_wait--;
      else if (m_phase == 2 && m_wait > 0) m_wait--;
      else if (m_iss) begin
        m_phase = (m_op == 1) ? 1 : 2;
        m_wait  = (m_op == 1) ? TRP - 1 : TRFC - 1;
      end else if (m_phase == 2 && !(m_catch && m_pend > 0)) m_phase = 0;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    int r0, s0;
    step(3);
    // R1: reset values
    chk(!ref_req && !ref_urgent && !cmd_valid && !act_block && !sweep_done, "R1 reset controls", {ref_req, ref_urgent, cmd_valid, act_block}, 0);
    chk(pending == 0 && row_shadow == 0, "R1 reset counters", pending + row_shadow, 0);
    rst_n = 1'b1;

    // R2: no tick, no refresh owed
    step(100);
    chk(ref_cnt == 0 && pending == 0, "R2 gated tick", ref_cnt, 0);

    // R10: steady distributed refresh, full grant
    tick = 1'b1;
    step(200);
    r0 = ref_cnt; s0 = sweep_cnt;
    step(3 * WIN);
    chk(ref_cnt - r0 == 3 * ROWS, "R10 refreshes per three windows", ref_cnt - r0, 3 * ROWS);
    chk(sweep_cnt - s0 == 3, "R10 sweeps per three windows", sweep_cnt - s0, 3);

    // R5: banks opened between refreshes
    for (int k = 0; k < 6; k++) begin
      reopen = 8'h21; step(1); reopen = '0; step(45);
    end
    chk(prea_cnt >= 3, "R5 precharge-all issued", prea_cnt, 3);

    // R3/R9: starve until the backlog is full, then urgent-only grant
    gmode = 2'd2;
    step(250);
    chk(pending == 4'(MAXP) && ref_urgent, "R3 saturation", pending, MAXP);
    tick = 1'b0;
    step(100);
    chk(pending == 4'(MAXP), "R2 gated tick at limit", pending, MAXP);
    chk(!cmd_valid && ref_req, "R11 no grant no command", cmd_valid, 0);
    tick = 1'b1;
    b2b_cnt = 0;
    gmode = 2'd0;
    step(200);
    chk(b2b_cnt >= MAXP - 1, "R9 back-to-back catch-up", b2b_cnt, MAXP - 1);
    chk(!ref_urgent, "R9 urgency released", ref_urgent, 0);

    gmode = 2'd1;
    step(300);
    chk(pending <= 1, "R4 backlog served", pending, 0);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule